// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A watchdog timer with a small memory-mapped register window. It has four 16-bit registers, selected by a 2-bit address and written with per-byte enables. A periodic tick enable drives a down-counter. When the counter first runs out, a status flag is set, an interrupt pulse can be raised, and the counter reloads itself. If software does not reload it before it runs out a second time, the block sets a second status flag and asserts a system reset pulse of fixed length.

Software keeps the system alive by writing the kick register. A halt bit stops the count. A no-reboot bit stops the second stage from resetting the system, and a lock input can pin that bit on. The status flags live on a separate power-on reset domain. Because of this, the second-timeout flag and the boot flag are still visible after the watchdog's own reset has been taken.

Register map (word address on `addr_i`): 0 kick (read: live count), 1 timer value, 2 control, 3 status.

Top module: `wdt2_regs`

## Requirements
- R1: Status bits (bit 0 first timeout, bit 1 second timeout, bit 2 boot; address 3) are set only by hardware. A write with byte 0 enabled clears each bit written as 1. Bits written as 0 are unchanged.
- R2: A single status write with both bit 1 and bit 2 set clears neither of them. Bit 1 and bit 2 are each cleared only by a write that sets that bit alone among the two.
- R3: Control bit 11 (halt) resets to 1. While it is 1, ticks do not change the count.
- R4: In the control register (address 2), bit 9 (no-reboot) holds the value last written and resets to 1. Every bit other than 9 and 11 reads as zero. Control bits are written only when byte 1 is enabled.
- R5: A write to address 0 with byte 0 enabled and any of data bits 4:0 nonzero loads the count from the timer value and cancels the second stage. If those bits are zero, the count is left unchanged.
- R6: Writing the timer value (address 1) does not change the running count until the next reload.
- R7: A written timer value is clamped to the range 4 to MAX. MAX is 63 when parameter WIDE is 0 and 1023 when WIDE is 1. The timer value and the count reset to MAX.
- R8: While halt is 0, each tick lowers the count by one. On a tick at count 1 (first stage), the block sets status bit 0, reloads the count from the timer value, and raises `irq_o` for exactly one cycle, but only if `irq_en_i` is 1.
- R9: A further expiry without a reload in between sets status bit 1 and drives `sys_rst_o` high for RST_CYC cycles, unless no-reboot is 1. A reload before that expiry makes the next expiry a first-stage one.
- R10: While `nr_lock_i` is 1, no-reboot reads as 1 and a write of 0 to it has no effect.
- R11: Status bits keep their values through `rst_ni`. `por_ni` clears bits 0 and 1 and sets bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, async; status domain |
| rst_ni | input | 1 | System reset, active low, async; timer and control |
| tick_i | input | 1 | Count enable pulse |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables (bit 0 low byte) |
| rdata_o | output | 16 | Read data of the selected register |
| irq_en_i | input | 1 | Enables the first-timeout interrupt |
| nr_lock_i | input | 1 | Forces no-reboot on |
| irq_o | output | 1 | First-timeout interrupt pulse |
| sys_rst_o | output | 1 | System reset request |

## Verification
Several properties are checked on every cycle: the count stays frozen under halt, a reload loads the timer value, the interrupt is gated by the enable, and a reset pulse never starts while no-reboot is on. The same checks cover the rule that status bits fall only on a matching clear, never on a combined clear of the second and boot bits, and that the lock holds no-reboot set. The scenarios are what show the two-stage sequence end to end. They cover the cancelling of the second stage by a reload, the clamping of timer values, and the read-back masking of the control register. They also show that the status flags survive a system reset, which no per-cycle property spans.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int unsigned DW = 16;

  typedef enum logic [1:0] {
    A_KICK = 2'd0,
    A_TVAL = 2'd1,
    A_CTRL = 2'd2,
    A_STAT = 2'd3
  } wdt_addr_e;

  localparam int B_HALT     = 11;
  localparam int B_NOREBOOT = 9;
  localparam int S_FIRST    = 0;
  localparam int S_SECOND   = 1;
  localparam int S_BOOT     = 2;
  localparam int N_STS      = 3;
  localparam int KICK_BITS  = 5;
  localparam int TMIN       = 4;
endpackage

// File: rtl/wdt2_timer.sv
module wdt2_timer #(
  parameter int CW      = 6,
  parameter int TMIN    = 4,
  parameter int TMAX    = 63,
  parameter int RST_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          halt_i,
  input  logic          kick_i,
  input  logic          tval_we_i,
  input  logic [15:0]   tval_raw_i,
  input  logic          noreboot_i,
  input  logic          irq_en_i,
  output logic [CW-1:0] tval_o,
  output logic [CW-1:0] cnt_o,
  output logic          first_set_o,
  output logic          second_set_o,
  output logic          irq_o,
  output logic          sys_rst_o
);
  localparam int RCW = $clog2(RST_CYC + 1);

  logic [CW-1:0]  tval_q, cnt_q, tval_clamp;
  logic           stage_q, irq_q, expire;
  logic [RCW-1:0] rst_cnt_q;

  always_comb begin
    if (tval_raw_i < 16'(TMIN))      tval_clamp = CW'(TMIN);
    else if (tval_raw_i > 16'(TMAX)) tval_clamp = CW'(TMAX);
    else                             tval_clamp = tval_raw_i[CW-1:0];
  end

  assign expire       = tick_i && !halt_i && !kick_i && (cnt_q == CW'(1));
  assign first_set_o  = expire && !stage_q;
  assign second_set_o = expire && stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tval_q    <= CW'(TMAX);
      cnt_q     <= CW'(TMAX);
      stage_q   <= 1'b0;
      irq_q     <= 1'b0;
      rst_cnt_q <= '0;
    end else begin
      irq_q <= first_set_o && irq_en_i;
      if (tval_we_i) tval_q <= tval_clamp;
      if (kick_i) begin
        cnt_q   <= tval_q;
        stage_q <= 1'b0;
      end else if (tick_i && !halt_i) begin
        if (cnt_q == CW'(1)) begin
          cnt_q   <= tval_q;
          stage_q <= 1'b1;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
      if (second_set_o && !noreboot_i) rst_cnt_q <= RCW'(RST_CYC);
      else if (rst_cnt_q != '0)        rst_cnt_q <= rst_cnt_q - RCW'(1);
    end
  end

  assign tval_o    = tval_q;
  assign cnt_o     = cnt_q;
  assign irq_o     = irq_q;
  assign sys_rst_o = (rst_cnt_q != '0);

  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !kick_i) |=> (cnt_q == $past(cnt_q))); // R3
  AST_KICK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == $past(tval_q))); // R5
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i)); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R8
  AST_NOREBOOT_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> !$past(noreboot_i)); // R9
  AST_TVAL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tval_we_i |=> (tval_q >= CW'(TMIN))); // R7
endmodule

// File: rtl/wdt2_status.sv
module wdt2_status
  import wdt2_pkg::*;
(
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic [N_STS-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [N_STS-1:0] clr_i,
  output logic [N_STS-1:0] sts_o
);
  logic [N_STS-1:0] clr_eff, sts_q;

  // second and boot flags must be cleared in separate writes
  always_comb begin
    clr_eff = clr_we_i ? clr_i : '0;
    if (clr_eff[S_SECOND] && clr_eff[S_BOOT]) begin
      clr_eff[S_SECOND] = 1'b0;
      clr_eff[S_BOOT]   = 1'b0;
    end
  end

  for (genvar i = 0; i < N_STS; i++) begin : g_bit
    localparam logic RV = (i == S_BOOT);
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)          sts_q[i] <= RV;
      else if (set_i[i])    sts_q[i] <= 1'b1;
      else if (clr_eff[i])  sts_q[i] <= 1'b0;
    end

    AST_STS_NOFALL: assert property (@(posedge clk_i) disable iff (!por_ni)
      $fell(sts_q[i]) |-> $past(clr_we_i && clr_i[i])); // R1
    AST_STS_NORISE: assert property (@(posedge clk_i) disable iff (!por_ni)
      $rose(sts_q[i]) |-> $past(set_i[i])); // R1
  end

  AST_PAIR_KEEP: assert property (@(posedge clk_i) disable iff (!por_ni)
    (clr_we_i && clr_i[S_SECOND] && clr_i[S_BOOT])
      |=> (!$fell(sts_q[S_SECOND]) && !$fell(sts_q[S_BOOT]))); // R2

  assign sts_o = sts_q;
endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
  import wdt2_pkg::*;
#(
  parameter bit WIDE    = 1'b0,
  parameter int RST_CYC = 16
) (
  input  logic        clk_i,
  input  logic        por_ni,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [15:0] wdata_i,
  input  logic [1:0]  be_i,
  output logic [15:0] rdata_o,
  input  logic        irq_en_i,
  input  logic        nr_lock_i,
  output logic        irq_o,
  output logic        sys_rst_o
);
  localparam int CW   = WIDE ? 10 : 6;
  localparam int TMAX = (1 << CW) - 1;

  logic             halt_q, nr_q, noreboot;
  logic             kick, tval_we, ctrl_we, stat_we;
  logic [15:0]      tval_ext, tval_merged;
  logic [CW-1:0]    tval, cnt;
  logic             first_set, second_set;
  logic [N_STS-1:0] sts;

  assign kick    = we_i && (addr_i == A_KICK) && be_i[0] && (|wdata_i[KICK_BITS-1:0]);
  assign tval_we = we_i && (addr_i == A_TVAL) && (|be_i);
  assign ctrl_we = we_i && (addr_i == A_CTRL) && be_i[1];
  assign stat_we = we_i && (addr_i == A_STAT) && be_i[0];

  assign tval_ext    = 16'(tval);
  assign tval_merged = {be_i[1] ? wdata_i[15:8] : tval_ext[15:8],
                        be_i[0] ? wdata_i[7:0]  : tval_ext[7:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b1;
      nr_q   <= 1'b1;
    end else begin
      if (ctrl_we) halt_q <= wdata_i[B_HALT];
      if (nr_lock_i)    nr_q <= 1'b1;
      else if (ctrl_we) nr_q <= wdata_i[B_NOREBOOT];
    end
  end

  assign noreboot = nr_q || nr_lock_i;

  wdt2_timer #(
    .CW(CW), .TMIN(TMIN), .TMAX(TMAX), .RST_CYC(RST_CYC)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .halt_i       (halt_q),
    .kick_i       (kick),
    .tval_we_i    (tval_we),
    .tval_raw_i   (tval_merged),
    .noreboot_i   (noreboot),
    .irq_en_i     (irq_en_i),
    .tval_o       (tval),
    .cnt_o        (cnt),
    .first_set_o  (first_set),
    .second_set_o (second_set),
    .irq_o        (irq_o),
    .sys_rst_o    (sys_rst_o)
  );

  wdt2_status u_status (
    .clk_i    (clk_i),
    .por_ni   (por_ni),
    .set_i    ({1'b0, second_set, first_set}),
    .clr_we_i (stat_we),
    .clr_i    (wdata_i[N_STS-1:0]),
    .sts_o    (sts)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_KICK: rdata_o = 16'(cnt);
      A_TVAL: rdata_o = tval_ext;
      A_CTRL: begin
        rdata_o[B_HALT]     = halt_q;
        rdata_o[B_NOREBOOT] = noreboot;
      end
      A_STAT: rdata_o = 16'(sts);
      default: rdata_o = '0;
    endcase
  end

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nr_lock_i |=> nr_q); // R10
endmodule

// File: tb/wdt2_regs_test.sv
module wdt2_regs_test;
  localparam int RST_CYC = 16;

  logic        clk_i = 1'b0;
  logic        por_ni = 1'b0, rst_ni = 1'b0;
  logic        tick_i = 1'b0, we_i = 1'b0;
  logic [1:0]  addr_i = '0, be_i = '0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic        irq_en_i = 1'b0, nr_lock_i = 1'b0;
  logic        irq_o, sys_rst_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  int    q_kind[$];
  int    q_exp[$];
  string q_tag[$];

  always #5 clk_i = ~clk_i;

  wdt2_regs #(.WIDE(1'b0), .RST_CYC(RST_CYC)) uut (
    .clk_i(clk_i), .por_ni(por_ni), .rst_ni(rst_ni), .tick_i(tick_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i),
    .rdata_o(rdata_o), .irq_en_i(irq_en_i), .nr_lock_i(nr_lock_i),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  // monitor: pops expected items and compares
  always @(negedge clk_i) begin
    if (q_kind.size() > 0) begin
      int k, e, a;
      string t;
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      a = (k == 0) ? int'(rdata_o) : (k == 1) ? int'(irq_o) : int'(sys_rst_o);
      n_run++;
      if (a != e) begin
        n_fail++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
      end
    end
  end

  task automatic chk_rd(input logic [1:0] a, input int e, input string t);
    @(posedge clk_i); #1;
    addr_i = a;
    q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk_i);
  endtask

  task automatic chk_out(input int k, input int e, input string t);
    q_kind.push_back(k); q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] b);
    @(posedge clk_i); #1;
    we_i = 1'b1; addr_i = a; wdata_i = d; be_i = b;
    @(posedge clk_i); #1;
    we_i = 1'b0; be_i = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1; tick_i = 1'b1;
      @(posedge clk_i); #1; tick_i = 1'b0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 por_ni = 1'b1; rst_ni = 1'b1;

    chk_rd(2, 16'h0A00, "R3 R4 ctrl reset");
    chk_rd(3, 16'h0004, "R11 status after por");
    chk_rd(1, 63, "R7 tval reset");
    chk_rd(0, 63, "R7 count reset");

    wr(1, 16'd2, 2'b11);     chk_rd(1, 4, "R7 clamp min");
    wr(1, 16'd2000, 2'b11);  chk_rd(1, 63, "R7 clamp max");
    wr(1, 16'd10, 2'b11);    chk_rd(0, 63, "R6 count unchanged by tval");
    wr(0, 16'h0020, 2'b11);  chk_rd(0, 63, "R5 zero low bits no reload");
    wr(0, 16'h0001, 2'b10);  chk_rd(0, 63, "R5 low byte disabled");
    wr(0, 16'h0001, 2'b11);  chk_rd(0, 10, "R5 reload");

    wr(2, 16'hFFFF, 2'b11);  chk_rd(2, 16'h0A00, "R4 ctrl mask");
    wr(2, 16'h0000, 2'b01);  chk_rd(2, 16'h0A00, "R4 ctrl needs byte1");
    wr(2, 16'h0000, 2'b11);  chk_rd(2, 16'h0000, "R4 ctrl clear");
    wr(2, 16'h0800, 2'b11);  ticks(3); chk_rd(0, 10, "R3 halt freezes");
    wr(2, 16'h0000, 2'b11);  ticks(3); chk_rd(0, 7, "R8 decrement");

    irq_en_i = 1'b1;
    ticks(6); chk_rd(0, 1, "R8 count at 1");
    ticks(1); chk_out(1, 1, "R8 irq on first expiry");
    chk_out(1, 0, "R8 irq one cycle");
    chk_rd(0, 10, "R8 auto reload");
    chk_rd(3, 16'h0005, "R8 first status");

    ticks(9); ticks(1); chk_out(2, 1, "R9 reset on second expiry");
    chk_rd(3, 16'h0007, "R9 second status");
    repeat (RST_CYC + 2) @(posedge clk_i);
    #1 chk_out(2, 0, "R9 reset pulse ends");

    #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    chk_rd(3, 16'h0007, "R11 status kept over rst_ni");
    chk_rd(2, 16'h0A00, "R3 ctrl after rst_ni");

    wr(3, 16'h0000, 2'b01);  chk_rd(3, 16'h0007, "R1 write zero no effect");
    wr(3, 16'h0006, 2'b01);  chk_rd(3, 16'h0007, "R2 combined clear ignored");
    wr(3, 16'h0001, 2'b01);  chk_rd(3, 16'h0006, "R1 clear first");
    wr(3, 16'h0002, 2'b01);  chk_rd(3, 16'h0004, "R2 clear second alone");
    wr(3, 16'h0004, 2'b01);  chk_rd(3, 16'h0000, "R2 clear boot alone");

    irq_en_i = 1'b0;
    wr(1, 16'd4, 2'b11);
    wr(0, 16'h0001, 2'b01);
    wr(2, 16'h0000, 2'b11);
    ticks(4); chk_out(1, 0, "R8 irq gated off");
    chk_rd(3, 16'h0001, "R8 first status without irq");

    wr(3, 16'h0001, 2'b01);
    wr(0, 16'h0010, 2'b01);
    ticks(4); chk_out(2, 0, "R9 reload cancels stage");
    chk_rd(3, 16'h0001, "R9 first stage after reload");

    wr(2, 16'h0200, 2'b11);
    ticks(4); chk_out(2, 0, "R9 noreboot blocks reset");
    chk_rd(3, 16'h0003, "R9 second status with noreboot");

    nr_lock_i = 1'b1;
    wr(2, 16'h0000, 2'b11);  chk_rd(2, 16'h0200, "R10 lock keeps noreboot");

    @(posedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule